// File: doc/BRIEF.md
# Multi-Bus Fault Address Capture

This block watches three bus decoders: the instruction-fetch bus, the data bus and the system bus. Each decoder reports a fault with a one-cycle strobe and a valid address beside it. While capture is switched on, the first fault seen on a bus freezes that bus's address into its own register and raises a per-bus fault-observed bit. The address stays frozen until software clears the status, which it does with a single write of any value to the status register. That write clears all three bits at once.

Software reaches the block through a small register window. The window holds a capture-enable register, a status register and three read-only captured-address registers. A combined flag reports when any status bit is set, so an interrupt or debug path can observe it without polling.

Top module: `bus_fault_capture`

Register window (index on `regSel`): 0 = capture enable (bit 0), 1 = fault status, 2 = instruction-bus address, 3 = data-bus address, 4 = system-bus address, 5..7 unmapped.

## Requirements
- R1: After reset, the enable bit, all three status bits, all three captured addresses and `faultAny` are 0.
- R2: A write to index 0 loads bit 0 of `regWrData` into the enable bit. Index 0 reads back that bit in bit 0 with zeros above it. Indexes 5 to 7 read as zero.
- R3: While enabled, a fault strobe on a bus whose status bit is clear stores that bus's address and sets its status bit. Both are visible on the read port from the cycle after the strobe.
- R4: While the enable bit is 0, fault strobes change neither status nor addresses.
- R5: A fault on a bus whose status bit is already set is ignored, and the stored address keeps the first captured value.
- R6: A write of any value to index 1 clears all three status bits in the next cycle. The captured addresses keep their values.
- R7: If a fault strobe arrives in the same cycle as a status-clear write, the fault wins. Its address is stored and its status bit stays or becomes 1, while the other bits clear.
- R8: Writing 0 to the enable bit leaves the existing status bits and captured addresses unchanged.
- R9: Writes to indexes 2 to 4 have no effect on the captured addresses.
- R10: Index 1 shows the instruction-bus fault in bit 0, the data-bus fault in bit 1 and the system-bus fault in bit 2, with 1 meaning a fault was seen. `faultAny` is the OR of these three bits.
- R11: Faults on several buses in the same cycle are each captured into their own register.
- R12: Captured addresses narrower than the read port are zero-extended on readback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regSel | input | 3 | Register index for read and write |
| regWrEn | input | 1 | Write strobe for the selected register |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data of the selected register (combinational) |
| iBusAddr | input | ADDR_W | Instruction-bus address |
| iBusFault | input | 1 | Instruction-bus fault strobe |
| dBusAddr | input | ADDR_W | Data-bus address |
| dBusFault | input | 1 | Data-bus fault strobe |
| sBusAddr | input | ADDR_W | System-bus address |
| sBusFault | input | 1 | System-bus fault strobe |
| faultAny | output | 1 | High while any status bit is set |

## Verification
The bench builds the block with `ADDR_W` set to 24, narrower than the 32-bit read port. This lets it drive addresses with their upper byte set and confirm that readback drops those bits and fills the top of the word with zeros. With that width, every status bit and address register stays fully observable through the read port. The bench also covers all the ordering cases: a clear and a fault in the same cycle, faults on several buses at once, and faults repeated while the status bit is set.

// File: rtl/bus_fault_pkg.sv
package bus_fault_pkg;
  localparam int NUM_BUS   = 3;
  localparam int DATA_W    = 32;
  localparam int REG_SEL_W = 3;

  // bus index doubles as status bit position
  localparam int BUS_INSTR = 0;
  localparam int BUS_DATA  = 1;
  localparam int BUS_SYS   = 2;

  localparam logic [REG_SEL_W-1:0] SEL_ENABLE = 3'd0;
  localparam logic [REG_SEL_W-1:0] SEL_STATUS = 3'd1;
  localparam int                   SEL_ADDR0  = 2;

  typedef struct packed {
    logic [NUM_BUS-1:0] loadAddr;
    logic [NUM_BUS-1:0] status;
    logic               captureEn;
  } faultStrobe_t;
endpackage

// File: rtl/bus_fault_ctrl.sv
module bus_fault_ctrl
  import bus_fault_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [REG_SEL_W-1:0] regSel,
  input  logic                 regWrEn,
  input  logic                 regWrBit0,
  input  logic [NUM_BUS-1:0]   faultIn,
  output faultStrobe_t         strobe
);
  logic               enReg;
  logic [NUM_BUS-1:0] statusReg;
  logic [NUM_BUS-1:0] loadVec;
  logic               clrReq;
  logic               enWr;

  always_comb begin
    clrReq = regWrEn && (regSel == SEL_STATUS);
    enWr   = regWrEn && (regSel == SEL_ENABLE);
    for (int i = 0; i < NUM_BUS; i++) begin
      // a pending clear reopens the channel in the same cycle
      loadVec[i] = enReg && faultIn[i] && (!statusReg[i] || clrReq);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg     <= 1'b0;
      statusReg <= '0;
    end else begin
      if (enWr) enReg <= regWrBit0;
      for (int i = 0; i < NUM_BUS; i++) begin
        if (loadVec[i])  statusReg[i] <= 1'b1;
        else if (clrReq) statusReg[i] <= 1'b0;
      end
    end
  end

  assign strobe.loadAddr  = loadVec;
  assign strobe.status    = statusReg;
  assign strobe.captureEn = enReg;

  // R3
  status_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|(statusReg & ~$past(statusReg))) |-> $past(enReg));

  // R6
  status_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|($past(statusReg) & ~statusReg)) |-> $past(clrReq));

  // R8
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(!enReg && !clrReq) |-> (statusReg == $past(statusReg)));
endmodule

// File: rtl/bus_fault_dp.sv
module bus_fault_dp
  import bus_fault_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [REG_SEL_W-1:0] regSel,
  input  logic [ADDR_W-1:0]    busAddr [NUM_BUS],
  input  faultStrobe_t         strobe,
  output logic [DATA_W-1:0]    rdData
);
  logic [ADDR_W-1:0] addrReg [NUM_BUS];

  for (genvar g = 0; g < NUM_BUS; g++) begin : g_chan
    always_ff @(posedge clk) begin
      if (!rstN)                   addrReg[g] <= '0;
      else if (strobe.loadAddr[g]) addrReg[g] <= busAddr[g];
    end

    // R5
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      ($past(strobe.status[g]) && !$past(strobe.loadAddr[g])) |-> $stable(addrReg[g]));
  end

  always_comb begin
    rdData = '0;
    if (regSel == SEL_ENABLE) rdData[0] = strobe.captureEn;
    else if (regSel == SEL_STATUS) rdData[NUM_BUS-1:0] = strobe.status;
    else begin
      for (int i = 0; i < NUM_BUS; i++) begin
        if (regSel == REG_SEL_W'(SEL_ADDR0 + i)) rdData[ADDR_W-1:0] = addrReg[i];
      end
    end
  end
endmodule

// File: rtl/bus_fault_capture.sv
module bus_fault_capture
  import bus_fault_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [REG_SEL_W-1:0] regSel,
  input  logic                 regWrEn,
  input  logic [DATA_W-1:0]    regWrData,
  output logic [DATA_W-1:0]    regRdData,
  input  logic [ADDR_W-1:0]    iBusAddr,
  input  logic                 iBusFault,
  input  logic [ADDR_W-1:0]    dBusAddr,
  input  logic                 dBusFault,
  input  logic [ADDR_W-1:0]    sBusAddr,
  input  logic                 sBusFault,
  output logic                 faultAny
);
  faultStrobe_t       strobe;
  logic [ADDR_W-1:0]  busAddr [NUM_BUS];
  logic [NUM_BUS-1:0] faultIn;

  assign busAddr[BUS_INSTR] = iBusAddr;
  assign busAddr[BUS_DATA]  = dBusAddr;
  assign busAddr[BUS_SYS]   = sBusAddr;
  assign faultIn[BUS_INSTR] = iBusFault;
  assign faultIn[BUS_DATA]  = dBusFault;
  assign faultIn[BUS_SYS]   = sBusFault;

  bus_fault_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWrEn(regWrEn),
    .regWrBit0(regWrData[0]), .faultIn(faultIn), .strobe(strobe)
  );

  bus_fault_dp #(.ADDR_W(ADDR_W)) dp_i (
    .clk(clk), .rstN(rstN), .regSel(regSel), .busAddr(busAddr),
    .strobe(strobe), .rdData(regRdData)
  );

  assign faultAny = |strobe.status;
endmodule

// File: tb/bus_fault_capture_tb.sv
module bus_fault_capture_tb_top;
  localparam int AW = 24;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  regSel = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [AW-1:0] iBusAddr = '0, dBusAddr = '0, sBusAddr = '0;
  logic        iBusFault = 1'b0, dBusFault = 1'b0, sBusFault = 1'b0;
  logic        faultAny;

  int checks = 0;
  int fails  = 0;

  // behavioural reference state
  int unsigned mAddr [3];
  bit          mStat [3];
  bit          mEn;

  always #5 clk = ~clk;

  bus_fault_capture #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData),
    .iBusAddr(iBusAddr), .iBusFault(iBusFault),
    .dBusAddr(dBusAddr), .dBusFault(dBusFault),
    .sBusAddr(sBusAddr), .sBusFault(sBusFault),
    .faultAny(faultAny)
  );

  function automatic int unsigned expRead(input int sel);
    int unsigned v = 0;
    if (sel == 0) v = mEn;
    else if (sel == 1) v = {mStat[2], mStat[1], mStat[0]};
    else if (sel >= 2 && sel <= 4) v = mAddr[sel-2];
    return v;
  endfunction

  task automatic step(input int sel, input bit wr, input int unsigned wd,
                      input bit [2:0] flt, input int unsigned a0,
                      input int unsigned a1, input int unsigned a2,
                      input string tag);
    int unsigned addrs [3];
    bit clr;
    bit ld [3];
    int unsigned exp;
    bit expAny;
    addrs[0] = a0 & 32'h00FF_FFFF;
    addrs[1] = a1 & 32'h00FF_FFFF;
    addrs[2] = a2 & 32'h00FF_FFFF;
    regSel = sel[2:0]; regWrEn = wr; regWrData = wd;
    iBusFault = flt[0]; dBusFault = flt[1]; sBusFault = flt[2];
    iBusAddr = a0[AW-1:0]; dBusAddr = a1[AW-1:0]; sBusAddr = a2[AW-1:0];
    @(posedge clk);
    if (!rstN) begin
      mEn = 0;
      for (int i = 0; i < 3; i++) begin mStat[i] = 0; mAddr[i] = 0; end
    end else begin
      clr = wr && (sel == 1);
      for (int i = 0; i < 3; i++) ld[i] = mEn && flt[i] && (!mStat[i] || clr);
      for (int i = 0; i < 3; i++) begin
        if (ld[i]) begin mStat[i] = 1; mAddr[i] = addrs[i]; end
        else if (clr) mStat[i] = 0;
      end
      if (wr && sel == 0) mEn = wd[0];
    end
    #1;
    regWrEn = 1'b0; iBusFault = 1'b0; dBusFault = 1'b0; sBusFault = 1'b0;
    #1;
    exp = expRead(sel);
    expAny = mStat[0] | mStat[1] | mStat[2];
    checks++;
    if (regRdData !== exp) begin
      fails++;
      $display("FAIL %s: sel %0d read 0x%08h expected 0x%08h", tag, sel, regRdData, exp);
    end
    checks++;
    if (faultAny !== expAny) begin
      fails++;
      $display("FAIL %s/R10: faultAny %b expected %b", tag, faultAny, expAny);
    end
  endtask

  task automatic sweep(input string tag);
    for (int s = 0; s < 8; s++) step(s, 0, 0, 3'b000, 0, 0, 0, tag);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    mEn = 0;
    for (int i = 0; i < 3; i++) begin mStat[i] = 0; mAddr[i] = 0; end
    // R1: reset state, including faults while in reset
    step(0, 1, 1, 3'b111, 32'h11, 32'h22, 32'h33, "R1");
    sweep("R1");
    #3 rstN = 1'b1;
    sweep("R1");
    // R4: faults ignored while disabled
    step(0, 0, 0, 3'b111, 32'hAAAA01, 32'hAAAA02, 32'hAAAA03, "R4");
    sweep("R4");
    // R2: only bit 0 of enable write matters; unmapped reads zero
    step(0, 1, 32'hFFFF_FFFE, 3'b000, 0, 0, 0, "R2");
    step(0, 1, 32'hFFFF_FFFF, 3'b000, 0, 0, 0, "R2");
    sweep("R2");
    // R3 / R12: instruction-bus capture with upper byte dropped
    step(1, 0, 0, 3'b001, 32'hFF12_3456, 32'h0, 32'h0, "R3_R12");
    sweep("R3");
    // R5: repeated fault ignored
    step(2, 0, 0, 3'b001, 32'h0065_4321, 0, 0, "R5");
    sweep("R5");
    // R11: data and system faults together (instruction still set)
    step(1, 0, 0, 3'b111, 32'h1, 32'hAB_CDEF, 32'h77_7777, "R11");
    sweep("R11");
    // R9: address registers read-only
    step(2, 1, 32'hDEAD_BEEF, 3'b000, 0, 0, 0, "R9");
    step(3, 1, 32'h1234_5678, 3'b000, 0, 0, 0, "R9");
    step(4, 1, 32'hFFFF_FFFF, 3'b000, 0, 0, 0, "R9");
    sweep("R9");
    // R8: disabling keeps state; faults then ignored
    step(0, 1, 0, 3'b000, 0, 0, 0, "R8");
    step(3, 0, 0, 3'b010, 0, 32'h99_9999, 0, "R8");
    sweep("R8");
    // R6: clear with zero value clears all bits, addresses kept
    step(0, 1, 1, 3'b000, 0, 0, 0, "R6");
    step(1, 1, 32'h0, 3'b000, 0, 0, 0, "R6");
    sweep("R6");
    // R7: clear and fault on same cycle while set
    step(1, 0, 0, 3'b101, 32'h00_1111, 0, 32'h00_5555, "R7");
    step(1, 1, 32'h7, 3'b001, 32'h00_2222, 0, 0, "R7");
    sweep("R7");
    // R7: clear and fresh fault on a clear channel
    step(1, 1, 32'hFF, 3'b010, 0, 32'h00_4444, 0, "R7");
    sweep("R7");
    // R10: each status bit alone
    step(1, 1, 0, 3'b000, 0, 0, 0, "R10");
    step(1, 0, 0, 3'b100, 0, 0, 32'h00_0ABC, "R10");
    step(1, 0, 0, 3'b000, 0, 0, 0, "R10");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule